// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Takeover

This block is an 8-pin bidirectional I/O port. A processor controls it through three registers on a small register bus. The direction register chooses, for each pin, whether its pad driver is on. The output latch holds the value that the pins drive. The port register returns the pin levels as sampled through a synchroniser.

Each pin can also be claimed by an on-chip peripheral. A claimed pin drives the peripheral's data instead of the latch value. A peripheral may also force a pin's driver on or off. None of these takeovers is ever stored in the direction register, so software can read-modify-write that register safely while a peripheral holds some of the pins.

Pads are modelled as three separate vectors: drive value, drive enable and sampled input.

Top module: `gpio_port`

## Requirements
- R1: While and after reset, the direction register reads 0xFF, the output latch reads 0x00, `pin_oe` is all zero, and `pin_out` (with no pin claimed) is all zero.
- R2: A write with `bus_addr`=1 loads `bus_wdata` into the output latch at the clock edge where `bus_wr` is high. A combinational read at address 1 returns the latch contents.
- R3: A write with `bus_addr`=0 also loads the output latch. Address 0 never reads the latch back.
- R4: A read at address 0 returns `pin_in` delayed by two clock edges, independent of the latch value.
- R5: A write with `bus_addr`=2 loads the direction register, which address 2 reads back. With no peripheral takeover, `pin_oe[i]` is the inverse of direction bit i (1 = input, driver off).
- R6: `pin_out[i]` equals `per_dout[i]` when `per_sel[i]`=1, and otherwise equals latch bit i.
- R7: `per_oe_force[i]`=1 turns `pin_oe[i]` on even when direction bit i is 1, but only while `per_sel[i]`=1. With `per_sel[i]`=0 the bit has no effect.
- R8: `per_ie_force[i]`=1 turns `pin_oe[i]` off, whatever the direction bit and `per_oe_force[i]` are.
- R9: No setting of `per_sel`, `per_oe_force` or `per_ie_force` changes the value read from the direction register.
- R10: Address 3 reads 0x00, and a write to it leaves both the latch and the direction register unchanged.
- R11: `per_din` carries the same synchronised pin values that an address 0 read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| pin_in | input | 8 | Sampled pad levels (asynchronous) |
| pin_out | output | 8 | Pad drive value |
| pin_oe | output | 8 | Pad drive enable, 1 = driving |
| per_sel | input | 8 | Per-pin peripheral claim of the output data path |
| per_dout | input | 8 | Peripheral data to drive on claimed pins |
| per_oe_force | input | 8 | Peripheral request to force the driver on (needs `per_sel`) |
| per_ie_force | input | 8 | Peripheral request to force the pin to input |
| per_din | output | 8 | Synchronised pin values for peripherals |

## Verification
Every one of the 256 data values is written through the latch address and again through the port address. Each latch readback is paired with a port read that shows a different, pin-driven value, which tells latch reads apart from port reads. The override logic is swept over 256 combinations of claim, force-out, force-in and peripheral data, each against a changing direction value. This separates force-in priority, force-out gating by the claim, and plain direction control, and it also confirms that the direction readback stays put. Pin input sweeps check the two-edge delay by sampling after one edge and again after two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT  = 2'd0,
        REG_LATCH = 2'd1,
        REG_DIR   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    // Per-pin peripheral request bundle
    typedef struct packed {
        logic claim;
        logic force_out;
        logic force_in;
        logic dout;
    } pin_ovr_t;

    // Per-pin resolved pad controls
    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            2'd0:    s = REG_PORT;
            2'd1:    s = REG_LATCH;
            2'd2:    s = REG_DIR;
            default: s = REG_NONE;
        endcase
        return s;
    endfunction

    // Force-in wins; force-out only counts while the pin is claimed.
    function automatic logic resolve_oe(input pin_ovr_t o, input logic dir_in);
        logic r;
        if (o.force_in)
            r = 1'b0;
        else if (o.claim && o.force_out)
            r = 1'b1;
        else
            r = ~dir_in;
        return r;
    endfunction

    function automatic logic resolve_val(input pin_ovr_t o, input logic lat_bit);
        return o.claim ? o.dout : lat_bit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_port_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      port_sync,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      dir_q
);

    reg_sel_e sel;
    logic     lat_we;
    logic     dir_we;

    assign sel    = decode_addr(addr);
    assign lat_we = wr && (sel == REG_PORT || sel == REG_LATCH);
    assign dir_we = wr && (sel == REG_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '1;
        end else begin
            if (lat_we) lat_q <= wdata;
            if (dir_we) dir_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            REG_PORT:  rdata = port_sync;
            REG_LATCH: rdata = lat_q;
            REG_DIR:   rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] per_sel,
    input  logic [W-1:0] per_dout,
    input  logic [W-1:0] per_oe_force,
    input  logic [W-1:0] per_ie_force,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_ovr_t ovr;
        pad_drv_t drv;

        assign ovr.claim     = per_sel[i];
        assign ovr.force_out = per_oe_force[i];
        assign ovr.force_in  = per_ie_force[i];
        assign ovr.dout      = per_dout[i];

        assign drv.oe  = resolve_oe(ovr, dir_q[i]);
        assign drv.val = resolve_val(ovr, lat_q[i]);

        assign pin_oe[i]  = drv.oe;
        assign pin_out[i] = drv.val;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    input  logic [W-1:0]      per_sel,
    input  logic [W-1:0]      per_dout,
    input  logic [W-1:0]      per_oe_force,
    input  logic [W-1:0]      per_ie_force,
    output logic [W-1:0]      per_din
);

    logic [W-1:0] port_sync;
    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (port_sync)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .port_sync (port_sync),
        .rdata     (bus_rdata),
        .lat_q     (lat_q),
        .dir_q     (dir_q)
    );

    gpio_pin_mux #(.W(W)) u_mux (
        .lat_q        (lat_q),
        .dir_q        (dir_q),
        .per_sel      (per_sel),
        .per_dout     (per_dout),
        .per_oe_force (per_oe_force),
        .per_ie_force (per_ie_force),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    assign per_din = port_sync;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pin_in,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      per_sel,
    input logic [W-1:0]      per_oe_force,
    input logic [W-1:0]      per_ie_force,
    input logic [W-1:0]      per_din,
    input logic [W-1:0]      lat_q,
    input logic [W-1:0]      dir_q
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_LAT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> (lat_q == $past(bus_wdata))); // R2

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2) |=> (dir_q == $past(bus_wdata))); // R5

    AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(lat_q) && $stable(dir_q))); // R10

    AST_FORCE_IN_OFF: assert property (@(posedge clk) disable iff (rst)
        ((per_ie_force & pin_oe) == '0)); // R8

    AST_FORCE_OUT_ON: assert property (@(posedge clk) disable iff (rst)
        ((per_sel & per_oe_force & ~per_ie_force & ~pin_oe) == '0)); // R7

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (per_din == $past(pin_in, 2))); // R4

endmodule

bind gpio_port gpio_port_chk #(.W(W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .pin_in       (pin_in),
    .pin_oe       (pin_oe),
    .per_sel      (per_sel),
    .per_oe_force (per_oe_force),
    .per_ie_force (per_ie_force),
    .per_din      (per_din),
    .lat_q        (lat_q),
    .dir_q        (dir_q)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] per_sel;
    logic [7:0] per_dout;
    logic [7:0] per_oe_force;
    logic [7:0] per_ie_force;
    logic [7:0] per_din;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_port i_gpio_port (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .per_sel      (per_sel),
        .per_dout     (per_dout),
        .per_oe_force (per_oe_force),
        .per_ie_force (per_ie_force),
        .per_din      (per_din)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_ovr();
        per_sel      = '0;
        per_dout     = '0;
        per_oe_force = '0;
        per_ie_force = '0;
    endtask

    initial begin
        logic [7:0] rd;
        logic [7:0] pv;
        rst       = 1'b1;
        bus_addr  = '0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        pin_in    = 8'h00;
        clear_ovr();
        repeat (3) @(negedge clk);

        // R1 during reset
        bus_read(2'd2, rd); check("R1 dir in reset", rd, 8'hFF);
        bus_read(2'd1, rd); check("R1 latch in reset", rd, 8'h00);
        check("R1 oe in reset", pin_oe, 8'h00);
        check("R1 out in reset", pin_out, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        bus_read(2'd2, rd); check("R1 dir after reset", rd, 8'hFF);
        check("R1 oe after reset", pin_oe, 8'h00);

        // R2/R3/R4 sweeps: latch through both addresses, port read shows pins
        for (int v = 0; v < 256; v++) begin
            pv     = ~v[7:0] ^ 8'h3C;
            pin_in = pv;
            bus_write(2'd1, v[7:0]);
            bus_read(2'd1, rd); check("R2 latch readback", rd, v[7:0]);
            @(negedge clk);
            bus_read(2'd0, rd); check("R4 port reads pins", rd, pv);
            check("R11 per_din", per_din, pv);
            bus_write(2'd0, ~v[7:0]);
            bus_read(2'd1, rd); check("R3 port write loads latch", rd, ~v[7:0]);
            bus_read(2'd0, rd); check("R3 port read not latch", rd, pv);
        end

        // R4 two-edge delay
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hA5;
        @(negedge clk);
        bus_read(2'd0, rd); check("R4 one edge still old", rd, 8'h00);
        check("R11 one edge still old", per_din, 8'h00);
        @(negedge clk);
        bus_read(2'd0, rd); check("R4 two edges new", rd, 8'hA5);

        // R5 direction sweep, no overrides
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd2, v[7:0]);
            bus_read(2'd2, rd); check("R5 dir readback", rd, v[7:0]);
            check("R5 oe from dir", pin_oe, ~v[7:0]);
        end

        // R6..R9 override sweep
        bus_write(2'd1, 8'h96);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] d;
            logic [7:0] eoe;
            logic [7:0] eout;
            d = v[7:0] * 8'd7 + 8'd13;
            bus_write(2'd2, d);
            per_sel      = v[7:0];
            per_oe_force = v[7:0] * 8'd29 + 8'd3;
            per_ie_force = (v[7:0] * 8'd53) ^ 8'h5A;
            per_dout     = ~v[7:0] ^ 8'h0F;
            #1;
            eoe  = ~per_ie_force & ((per_sel & per_oe_force) | ~d);
            eout = (per_sel & per_dout) | (~per_sel & 8'h96);
            check("R6 out mux", pin_out, eout);
            check("R7/R8 oe resolve", pin_oe, eoe);
            bus_read(2'd2, rd); check("R9 dir unchanged", rd, d);
            clear_ovr();
        end

        // R7 force-out without claim has no effect
        bus_write(2'd2, 8'hFF);
        per_oe_force = 8'hFF;
        #1; check("R7 force-out needs claim", pin_oe, 8'h00);
        per_sel = 8'h0F;
        #1; check("R7 force-out with claim", pin_oe, 8'h0F);
        // R8 force-in beats force-out and dir 0
        bus_write(2'd2, 8'h00);
        per_ie_force = 8'h33;
        #1; check("R8 force-in priority", pin_oe, 8'hCC);
        clear_ovr();

        // R10 invalid address
        bus_write(2'd1, 8'h5A);
        bus_write(2'd2, 8'hC3);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rd); check("R10 bad addr reads 0", rd, 8'h00);
        bus_read(2'd1, rd); check("R10 latch kept", rd, 8'h5A);
        bus_read(2'd2, rd); check("R10 dir kept", rd, 8'hC3);
        #1; check("R10 pins kept", pin_out, 8'h5A);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_read(2'd1, rd); check("R1 latch re-reset", rd, 8'h00);
        bus_read(2'd2, rd); check("R1 dir re-reset", rd, 8'hFF);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule